// File: doc/BRIEF.md
# System Control Register Bank

A bank of 32-bit global control words for a chip's housekeeping space. Software reaches it over a word-addressed bus with separate read and write channels; each channel carries a byte address inside a 4 KiB window and a size code. Every word slot follows one fixed write rule:
- ordinary read/write;
- read-only;
- write-one-to-clear;
- write-one-to-set.

Every slot reloads a known value on cold reset. Two slots take that value from external inputs sampled during cold reset: a power-on strap word and a module-disable configuration word. The other slots use fixed constants.

A secondary processor can spin on a scratch word while it boots. For that reason a write becomes readable on the very next cycle. Read data comes out of a register one cycle after the request.

An error flag rises in that same cycle when an access in the previous cycle was illegal. An access is illegal when:
- it is misaligned or not a full word;
- it addresses a slot past the defined range;
- it writes a read-only slot.

Top module: `sysctl_bank`

## Requirements
- R1: After cold reset the following slots hold these values, and every slot not named in R1 or R2 reads zero:
  - byte offset 0x000: 0x04A92750
  - byte offset 0x014: 0x0000FFFF
  - byte offset 0x03C: 0x0000035E
  - byte offset 0x06C: 0x80000000
  - byte offset 0x13C: 0x00000008
  - byte offsets 0x140 and 0x144: 0x034730E4
- R2: Cold reset loads offset 0x004 from `strapIn` and offset 0x07C from `cfgIn`. Later changes on those inputs have no effect until the next cold reset.
- R3: Every in-range slot not listed in R4, R5 or R6 is read/write; the written word is stored bit for bit. Examples are the scratch word at 0x13C and unused slots such as 0x008. A write in one cycle is returned by a read in the next cycle.
- R4: Offsets 0x000, 0x004 and 0x040 are read-only. A legal-format write to one of them leaves it unchanged and raises `busErr` in the following cycle.
- R5: Offsets 0x06C and 0x0D4 are write-one-to-clear: new value = old value AND NOT write data.
- R6: Offsets 0x070 and 0x07C are write-one-to-set: new value = old value OR write data. Software can never clear their bits.
- R7: A byte address whose word index (address bits 11:2) is 82 or more is out of range. A read there returns zero, a write there changes no slot, and both raise `busErr` in the following cycle.
- R8: Only full-word aligned accesses are legal: size code 2 (four bytes) with address bits 1:0 equal to zero. Any other size code or alignment is illegal, and such an access behaves as described for out-of-range accesses in R7.
- R9: Read data is registered. A legal read in cycle N shows its slot on `busRdata` after edge N. A read and a write to the same slot in the same cycle return the value from before the write. A cycle with no read leaves `busRdata` zero. A cycle with no illegal access leaves `busErr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Synchronous cold reset, active low; reloads every slot |
| rdEn | input | 1 | Read request this cycle |
| rdAddr | input | 12 | Read byte address |
| rdSize | input | 3 | Read size code, log2 of the byte count |
| wrEn | input | 1 | Write request this cycle |
| wrAddr | input | 12 | Write byte address |
| wrSize | input | 3 | Write size code, log2 of the byte count |
| wrData | input | 32 | Write data, bit i goes to slot bit i |
| strapIn | input | 32 | Power-on strap word sampled during cold reset |
| cfgIn | input | 32 | Module-disable word sampled during cold reset |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | Registered illegal-access flag |

## Verification
The assertions assume two things about the inputs:
- the request inputs are stable and known across each rising edge;
- cold reset is held over at least one edge, because the slots reset synchronously.

The stimulus drives every request on the falling edge and holds cold reset low for three edges. It changes `strapIn` and `cfgIn` only while the bank is out of reset, except for the deliberate reload test. The address, size and rule decode are checked against an independent model kept in the bench.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DataW    = 32;
  localparam int AddrW    = 12;              // 4 KiB window
  localparam int WordW    = AddrW - 2;
  localparam int NumSlots = 82;              // word slots 0x000..0x144
  localparam int IdxW     = $clog2(NumSlots);
  localparam int SizeW    = 3;
  localparam logic [SizeW-1:0] SizeWord = 3'd2;

  typedef enum logic [1:0] {RuleRw, RuleRo, RuleW1c, RuleW1s} rule_e;
  typedef enum logic [1:0] {SrcConst, SrcStrap, SrcCfg} rstsrc_e;

  typedef struct packed {
    logic            rdStb;
    logic [IdxW-1:0] rdIdx;
    logic            wrStb;
    logic [IdxW-1:0] wrIdx;
    logic            accErr;
  } strobe_t;

  function automatic rule_e slotRule(input int idx);
    case (idx)
      0, 1, 16: return RuleRo;
      27, 53:   return RuleW1c;
      28, 31:   return RuleW1s;
      default:  return RuleRw;
    endcase
  endfunction

  function automatic rstsrc_e slotRstSrc(input int idx);
    case (idx)
      1:       return SrcStrap;
      31:      return SrcCfg;
      default: return SrcConst;
    endcase
  endfunction

  function automatic logic [DataW-1:0] slotRstConst(input int idx);
    case (idx)
      0:       return 32'h04A9_2750;
      5:       return 32'h0000_FFFF;
      15:      return 32'h0000_035E;
      27:      return 32'h8000_0000;
      79:      return 32'h0000_0008;
      80, 81:  return 32'h0347_30E4;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic             rdEn,
  input  logic [AddrW-1:0] rdAddr,
  input  logic [SizeW-1:0] rdSize,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [SizeW-1:0] wrSize,
  output strobe_t          stb
);
  localparam logic [WordW-1:0] SlotLimit = WordW'(NumSlots);

  logic [WordW-1:0] rdWord, wrWord;
  logic rdFmtOk, wrFmtOk, rdInRange, wrInRange, wrIsRo, rdOk, wrOk;

  always_comb begin
    rdWord    = rdAddr[AddrW-1:2];
    wrWord    = wrAddr[AddrW-1:2];
    rdFmtOk   = (rdSize == SizeWord) && (rdAddr[1:0] == 2'b00);
    wrFmtOk   = (wrSize == SizeWord) && (wrAddr[1:0] == 2'b00);
    rdInRange = rdWord < SlotLimit;
    wrInRange = wrWord < SlotLimit;
    wrIsRo    = slotRule(int'(wrWord)) == RuleRo;
    rdOk      = rdFmtOk && rdInRange;
    wrOk      = wrFmtOk && wrInRange && !wrIsRo;

    stb.rdStb  = rdEn && rdOk;
    stb.rdIdx  = rdWord[IdxW-1:0];
    stb.wrStb  = wrEn && wrOk;
    stb.wrIdx  = wrWord[IdxW-1:0];
    stb.accErr = (rdEn && !rdOk) || (wrEn && !wrOk);
  end
endmodule

// File: rtl/sysctl_slot.sv
module sysctl_slot
  import sysctl_pkg::*;
#(
  parameter rule_e Rule = RuleRw
) (
  input  logic             clk,
  input  logic             coldRstN,
  input  logic [DataW-1:0] rstVal,
  input  logic             wrHit,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!coldRstN) begin
      q <= rstVal;
    end else if (wrHit) begin
      case (Rule)
        RuleRw:  q <= wrData;
        RuleW1c: q <= q & ~wrData;
        RuleW1s: q <= q | wrData;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             coldRstN,
  input  strobe_t          stb,
  input  logic [DataW-1:0] wrData,
  input  logic [DataW-1:0] strapIn,
  input  logic [DataW-1:0] cfgIn,
  output logic [DataW-1:0] busRdata,
  output logic             busErr
);
  logic [DataW-1:0] slotQ [NumSlots];
  logic [DataW-1:0] rdMux;

  for (genvar i = 0; i < NumSlots; i++) begin : g_slot
    localparam rule_e   SlotRule = slotRule(i);
    localparam rstsrc_e SlotSrc  = slotRstSrc(i);
    logic [DataW-1:0] rstVal;
    logic             hit;

    if (SlotSrc == SrcStrap) begin : g_strap
      assign rstVal = strapIn;
    end else if (SlotSrc == SrcCfg) begin : g_cfg
      assign rstVal = cfgIn;
    end else begin : g_const
      assign rstVal = slotRstConst(i);
    end

    assign hit = stb.wrStb && (stb.wrIdx == IdxW'(i));

    sysctl_slot #(.Rule(SlotRule)) u_slot (
      .clk      (clk),
      .coldRstN (coldRstN),
      .rstVal   (rstVal),
      .wrHit    (hit),
      .wrData   (wrData),
      .q        (slotQ[i])
    );
  end

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < NumSlots; k++) begin
      if (stb.rdIdx == IdxW'(k)) rdMux = slotQ[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!coldRstN) begin
      busRdata <= '0;
      busErr   <= 1'b0;
    end else begin
      busRdata <= stb.rdStb ? rdMux : '0;
      busErr   <= stb.accErr;
    end
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             coldRstN,
  input  logic             rdEn,
  input  logic [AddrW-1:0] rdAddr,
  input  logic [SizeW-1:0] rdSize,
  input  logic             wrEn,
  input  logic [AddrW-1:0] wrAddr,
  input  logic [SizeW-1:0] wrSize,
  input  logic [DataW-1:0] wrData,
  input  logic [DataW-1:0] strapIn,
  input  logic [DataW-1:0] cfgIn,
  output logic [DataW-1:0] busRdata,
  output logic             busErr
);
  strobe_t stb;

  sysctl_decode u_decode (
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .rdSize (rdSize),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrSize (wrSize),
    .stb    (stb)
  );

  sysctl_regs u_regs (
    .clk      (clk),
    .coldRstN (coldRstN),
    .stb      (stb),
    .wrData   (wrData),
    .strapIn  (strapIn),
    .cfgIn    (cfgIn),
    .busRdata (busRdata),
    .busErr   (busErr)
  );
endmodule

// File: rtl/sysctl_bank_chk.sv
module sysctl_bank_chk
  import sysctl_pkg::*;
(
  input logic             clk,
  input logic             coldRstN,
  input logic             rdEn,
  input logic [AddrW-1:0] rdAddr,
  input logic [SizeW-1:0] rdSize,
  input logic             wrEn,
  input logic [AddrW-1:0] wrAddr,
  input logic [SizeW-1:0] wrSize,
  input logic [DataW-1:0] busRdata,
  input logic             busErr
);
  localparam logic [WordW-1:0] SlotLimit = WordW'(NumSlots);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!coldRstN)
    (!rdEn && !wrEn) |=> (busRdata == '0 && !busErr)); // R9

  AST_BAD_FORMAT_READ: assert property (@(posedge clk) disable iff (!coldRstN)
    (rdEn && (rdSize != SizeWord || rdAddr[1:0] != 2'b00)) |=> (busErr && busRdata == '0)); // R8

  AST_OOR_READ: assert property (@(posedge clk) disable iff (!coldRstN)
    (rdEn && rdAddr[AddrW-1:2] >= SlotLimit) |=> (busErr && busRdata == '0)); // R7

  AST_RO_WRITE_ERR: assert property (@(posedge clk) disable iff (!coldRstN)
    (wrEn && wrSize == SizeWord &&
     (wrAddr == 12'h000 || wrAddr == 12'h004 || wrAddr == 12'h040)) |=> busErr); // R4

  AST_LEGAL_READ_NO_ERR: assert property (@(posedge clk) disable iff (!coldRstN)
    (rdEn && !wrEn && rdSize == SizeWord && rdAddr[1:0] == 2'b00 &&
     rdAddr[AddrW-1:2] < SlotLimit) |=> !busErr); // R9
endmodule

bind sysctl_bank sysctl_bank_chk u_chk (.*);

// File: tb/tb_sysctl_bank.sv
module tb_sysctl_bank;
  logic        clk = 1'b0;
  logic        coldRstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [11:0] rdAddr = '0, wrAddr = '0;
  logic [2:0]  rdSize = 3'd2, wrSize = 3'd2;
  logic [31:0] wrData = '0, strapIn = '0, cfgIn = '0;
  logic [31:0] busRdata;
  logic        busErr;

  int checks = 0, bad = 0;
  bit finished = 0;
  logic [31:0] model [82];
  logic [31:0] qRd [$];
  logic        qErr [$];
  string       qTag [$];

  always #4 clk = ~clk;  // 125 MHz

  sysctl_bank dut (.*);

  function automatic int ruleOf(input int idx);  // 0 rw, 1 ro, 2 w1c, 3 w1s
    if (idx == 0 || idx == 1 || idx == 16) return 1;
    if (idx == 27 || idx == 53) return 2;
    if (idx == 28 || idx == 31) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] resetOf(input int idx, input logic [31:0] s, input logic [31:0] c);
    case (idx)
      0: return 32'h04A92750;  1: return s;  5: return 32'h0000FFFF;
      15: return 32'h0000035E; 27: return 32'h80000000; 31: return c;
      79: return 32'h00000008; 80: return 32'h034730E4; 81: return 32'h034730E4;
      default: return 32'h0;
    endcase
  endfunction

  task automatic cycle(input logic re, input logic [11:0] ra, input logic [2:0] rs,
                       input logic we, input logic [11:0] wa, input logic [2:0] ws,
                       input logic [31:0] wd, input string tag);
    int ri, wi;
    bit rOk, wOk;
    logic [31:0] er;
    @(negedge clk);
    rdEn = re; rdAddr = ra; rdSize = rs; wrEn = we; wrAddr = wa; wrSize = ws; wrData = wd;
    ri = int'(ra[11:2]); wi = int'(wa[11:2]);
    rOk = (rs == 3'd2) && (ra[1:0] == 2'b00) && (ri < 82);
    wOk = (ws == 3'd2) && (wa[1:0] == 2'b00) && (wi < 82) && (ruleOf(wi) != 1);
    er = (re && rOk) ? model[ri] : 32'h0;
    if (we && wOk) begin
      case (ruleOf(wi))
        2: model[wi] = model[wi] & ~wd;
        3: model[wi] = model[wi] | wd;
        default: model[wi] = wd;
      endcase
    end
    qRd.push_back(er);
    qErr.push_back((re && !rOk) || (we && !wOk));
    qTag.push_back(tag);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    cycle(1, a, 3'd2, 0, 12'h0, 3'd2, 32'h0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cycle(0, 12'h0, 3'd2, 1, a, 3'd2, d, tag);
  endtask
  task automatic idle(input string tag);
    cycle(0, 12'h0, 3'd2, 0, 12'h0, 3'd2, 32'h0, tag);
  endtask

  task automatic coldReset(input logic [31:0] s, input logic [31:0] c);
    @(negedge clk);
    rdEn = 0; wrEn = 0; coldRstN = 0; strapIn = s; cfgIn = c;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 82; i++) model[i] = resetOf(i, s, c);
    coldRstN = 1;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (qRd.size() > 0) begin
        logic [31:0] er; logic ee; string t;
        er = qRd.pop_front(); ee = qErr.pop_front(); t = qTag.pop_front();
        checks++;
        if (busRdata !== er || busErr !== ee) begin
          bad++;
          $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b", t, busRdata, busErr, er, ee);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 100000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin : stim
    coldReset(32'hA5A5_0F0F, 32'h0000_1234);
    idle("R9 idle after reset");
    for (int i = 0; i < 82; i++) rd(12'(i * 4), (i == 1 || i == 31) ? "R2 strap reset" : "R1 reset value");

    // R2: straps matter only during cold reset
    @(negedge clk); strapIn = 32'h1111_2222; cfgIn = 32'h3333_4444;
    rd(12'h004, "R2 strap held"); rd(12'h07C, "R2 cfg held");
    coldReset(32'h5555_6666, 32'h0000_0080);
    rd(12'h004, "R2 strap reload"); rd(12'h07C, "R2 cfg reload");

    // R3: read/write slots
    wr(12'h13C, 32'hDEAD_BEEF, "R3 scratch write"); rd(12'h13C, "R3 scratch next read");
    wr(12'h008, 32'h1234_5678, "R3 hole write");    rd(12'h008, "R3 hole read");
    wr(12'h030, 32'h0000_0001, "R3 bit0");          rd(12'h030, "R3 bit0 read");
    wr(12'h030, 32'h8000_0000, "R3 bit31");         rd(12'h030, "R3 bit31 read");

    // R4: read-only slots
    wr(12'h000, 32'hFFFF_FFFF, "R4 ro write id");    rd(12'h000, "R4 id unchanged");
    wr(12'h004, 32'h0,         "R4 ro write strap"); rd(12'h004, "R4 strap unchanged");
    wr(12'h040, 32'hFFFF_FFFF, "R4 ro write status"); rd(12'h040, "R4 status unchanged");

    // R5: write-one-to-clear
    wr(12'h06C, 32'h0, "R5 w1c zero");         rd(12'h06C, "R5 w1c kept");
    wr(12'h06C, 32'h8000_0000, "R5 w1c bit31"); rd(12'h06C, "R5 w1c cleared");
    wr(12'h0D4, 32'hFFFF_FFFF, "R5 w1c all");  rd(12'h0D4, "R5 w1c stays zero");

    // R6: write-one-to-set
    wr(12'h070, 32'h0000_000F, "R6 w1s low"); wr(12'h070, 32'h0000_00F0, "R6 w1s high");
    rd(12'h070, "R6 w1s merged");
    wr(12'h070, 32'h0, "R6 w1s zero"); rd(12'h070, "R6 w1s not cleared");
    wr(12'h07C, 32'h0000_0001, "R6 w1s cfg"); rd(12'h07C, "R6 w1s cfg or");

    // R7: out-of-range
    rd(12'h148, "R7 oor read"); rd(12'hFFC, "R7 oor top read");
    wr(12'h148, 32'hCAFE_F00D, "R7 oor write"); wr(12'hFFC, 32'hFFFF_FFFF, "R7 oor top write");
    for (int i = 0; i < 82; i++) rd(12'(i * 4), "R7 no slot changed");

    // R8: size and alignment
    cycle(1, 12'h13C, 3'd1, 0, 12'h0, 3'd2, 32'h0, "R8 half read");
    cycle(1, 12'h13D, 3'd2, 0, 12'h0, 3'd2, 32'h0, "R8 unaligned read");
    cycle(0, 12'h0, 3'd2, 1, 12'h13C, 3'd0, 32'h1, "R8 byte write");
    cycle(0, 12'h0, 3'd2, 1, 12'h13E, 3'd2, 32'h2, "R8 unaligned write");
    cycle(0, 12'h0, 3'd2, 1, 12'h13C, 3'd3, 32'h3, "R8 wide write");
    rd(12'h13C, "R8 scratch unchanged");

    // R9: same-cycle read and write, registered timing
    cycle(1, 12'h13C, 3'd2, 1, 12'h13C, 3'd2, 32'h0BAD_C0DE, "R9 read pre-write");
    rd(12'h13C, "R9 read post-write");
    cycle(1, 12'h06C, 3'd2, 1, 12'h148, 3'd2, 32'h0, "R9 good read with bad write");
    idle("R9 idle quiet");

    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule